// File: doc/BRIEF.md
# Line-Scheduled Ancillary Word Inserter

The block sits in a 10-bit video word path. It places a prepared ancillary packet into the horizontal blanking of up to two chosen lines in every frame. An upstream packet buffer offers its head word, the length of the packet at its head and an empty flag. The inserter pops words through a single read strobe and muxes them onto the output in place of the blanking words. All other input words pass through one register, so both mux paths have the same latency.

Insertion is gated by an arming state machine. Raising the enable arms the block only at the next frame start. Once armed, dropping the enable has no effect. The only way to disarm is the bypass mode code. Leaving bypass starts a fixed wait, after which the block re-arms at once if the enable is high. If the enable is low it returns to idle. A packet that does not fit in the blanking interval is cut at the end of blanking, and a one-cycle overflow flag is raised.

Top module: `anc_line_inserter`

## Requirements
- R1: While rst_ni is low, vid_o is 0, overflow_o is 0 and buf_rd_o is 0.
- R2: For every cycle that does not insert a word, vid_o in the next cycle equals vid_i of this cycle.
- R3: With mode_i not 2'b11, a rising ins_en_i arms the block at the first sof_i pulse sampled after the enable. No word is inserted in the frame during which the enable was raised.
- R4: A line is a slot line when line_i equals line_a_i or line_b_i and that register is non-zero. A line that matches both registers gets a single packet.
- R5: Once armed, the packet is inserted on the slot lines of every later frame.
- R6: On a slot line, the first cycle with hblank_i high starts a packet if buf_empty_i is 0 and buf_len_i is non-zero. buf_rd_o is high for each word taken. Word k of the packet (buf_data_i in the cycle it is read) appears on vid_o one cycle later, in place of blanking word k.
- R7: buf_rd_o is high only while hblank_i is high. If hblank_i falls before buf_len_i words are taken, reading stops, and overflow_o is high for exactly one cycle: the cycle after the first non-blanking input. A packet of exactly the blanking length raises no flag.
- R8: Once armed, driving ins_en_i low does not stop insertion.
- R9: mode_i equal to 2'b11 disarms the block in the next cycle, including mid-packet. No word is read while bypass is held.
- R10: When mode_i leaves 2'b11 in cycle c, the block re-arms in cycle c+1+REARM_CYC if ins_en_i is high at the end of the wait. Otherwise it goes idle and needs a new enable and a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vid_i | input | VID_W | Incoming video word |
| line_i | input | LINE_W | Current line number |
| sof_i | input | 1 | One-cycle frame start pulse |
| hblank_i | input | 1 | High during horizontal blanking |
| ins_en_i | input | 1 | Insertion enable |
| line_a_i | input | LINE_W | First slot line, 0 = unused |
| line_b_i | input | LINE_W | Second slot line, 0 = unused |
| mode_i | input | 2 | Mode; 2'b11 = bypass |
| buf_empty_i | input | 1 | Packet buffer empty |
| buf_len_i | input | LEN_W | Word count of packet at buffer head |
| buf_data_i | input | VID_W | Head word of packet buffer |
| buf_rd_o | output | 1 | Pop one word from buffer |
| vid_o | output | VID_W | Output video word |
| overflow_o | output | 1 | One-cycle flag: packet cut at blanking end |

## Verification
A wrong arming state shows up as a packet present or missing on a whole slot line. This is visible within one line time of the frame start, or of the end of the re-arm wait. The wait is probed at the exact line boundary, so a count one short inserts a line early. A wrong word counter shows up within the same blanking interval. It appears as a shifted or repeated word, a read strobe during active video, or a misplaced overflow pulse in the first active cycle.

// File: rtl/anc_ins_pkg.sv
package anc_ins_pkg;
  localparam int unsigned VID_W_DEF  = 10;
  localparam int unsigned LINE_W_DEF = 11;
  localparam logic [1:0]  MODE_BYP   = 2'b11;

  typedef enum logic [2:0] {
    ARM_IDLE,
    ARM_PEND,
    ARM_ON,
    ARM_BYP,
    ARM_WAIT
  } arm_st_t;
endpackage

// File: rtl/anc_arm_ctrl.sv
module anc_arm_ctrl
  import anc_ins_pkg::*;
#(
  parameter int unsigned REARM_CYC = 2200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ins_en_i,
  input  logic       sof_i,
  input  logic [1:0] mode_i,
  output logic       armed_o
);
  localparam int unsigned CNT_W = $clog2(REARM_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REARM_CYC - 1);

  arm_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             byp;

  assign byp = (mode_i == MODE_BYP);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ARM_IDLE: if (byp) st_d = ARM_BYP; else if (ins_en_i) st_d = ARM_PEND;
      ARM_PEND: if (byp) st_d = ARM_BYP; else if (sof_i) st_d = ARM_ON;
      ARM_ON:   if (byp) st_d = ARM_BYP;
      ARM_BYP:  if (!byp) begin st_d = ARM_WAIT; cnt_d = '0; end
      ARM_WAIT: begin
        if (byp) st_d = ARM_BYP;
        else if (cnt_q == CNT_LAST) st_d = ins_en_i ? ARM_ON : ARM_IDLE;
        else cnt_d = cnt_q + 1'b1;
      end
      default:  st_d = ARM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ARM_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign armed_o = (st_q == ARM_ON);

  AST_BYP_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYP) |=> !armed_o); // R9
  AST_EN_DROP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && mode_i != MODE_BYP) |=> armed_o); // R8
  AST_ARM_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> ($past(sof_i) || $past(st_q == ARM_WAIT))); // R3
  AST_WAIT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(armed_o) && $past(st_q == ARM_WAIT)) |-> ($past(cnt_q) == CNT_LAST)); // R10
endmodule

// File: rtl/anc_line_match.sv
module anc_line_match #(
  parameter int unsigned LINE_W    = 11,
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] slot_line_i [NUM_SLOTS],
  output logic              hit_o
);
  logic [NUM_SLOTS-1:0] slot_hit;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // zero marks an unused slot
    assign slot_hit[s] = (slot_line_i[s] != '0) && (slot_line_i[s] == line_i);
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/anc_ins_engine.sv
module anc_ins_engine #(
  parameter int unsigned VID_W = 10,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             hit_i,
  input  logic             hblank_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic             buf_empty_i,
  input  logic [LEN_W-1:0] buf_len_i,
  input  logic [VID_W-1:0] buf_data_i,
  output logic             buf_rd_o,
  output logic [VID_W-1:0] vid_o,
  output logic             overflow_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             hb_q, run_q, ovf_q;
  logic [LEN_W-1:0] rem_q;
  logic [VID_W-1:0] vid_q;
  logic             blank_rise, start, cont, rd;

  assign blank_rise = hblank_i & ~hb_q;
  assign start      = armed_i & blank_rise & hit_i & ~buf_empty_i & (buf_len_i != '0);
  assign cont       = armed_i & run_q & hblank_i;
  assign rd         = start | cont;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q  <= 1'b1;  // no start in a blanking already running at reset
      run_q <= 1'b0;
      rem_q <= '0;
      ovf_q <= 1'b0;
      vid_q <= '0;
    end else begin
      hb_q  <= hblank_i;
      vid_q <= rd ? buf_data_i : vid_i;
      ovf_q <= 1'b0;
      if (!armed_i) begin
        run_q <= 1'b0;
      end else if (start) begin
        run_q <= (buf_len_i > ONE);
        rem_q <= buf_len_i - ONE;
      end else if (run_q) begin
        if (!hblank_i) begin
          run_q <= 1'b0;
          ovf_q <= 1'b1;
        end else begin
          rem_q <= rem_q - ONE;
          if (rem_q == ONE) run_q <= 1'b0;
        end
      end
    end
  end

  assign buf_rd_o   = rd;
  assign vid_o      = vid_q;
  assign overflow_o = ovf_q;

  AST_RD_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |-> (hblank_i && armed_i)); // R7
  AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> !overflow_o); // R7
  AST_PASS_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_rd_o |=> (vid_o == $past(vid_i))); // R2
  AST_INS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |=> (vid_o == $past(buf_data_i))); // R6
endmodule

// File: rtl/anc_line_inserter.sv
module anc_line_inserter
  import anc_ins_pkg::*;
#(
  parameter int unsigned VID_W     = VID_W_DEF,
  parameter int unsigned LINE_W    = LINE_W_DEF,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned REARM_CYC = 2200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VID_W-1:0]  vid_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              sof_i,
  input  logic              hblank_i,
  input  logic              ins_en_i,
  input  logic [LINE_W-1:0] line_a_i,
  input  logic [LINE_W-1:0] line_b_i,
  input  logic [1:0]        mode_i,
  input  logic              buf_empty_i,
  input  logic [LEN_W-1:0]  buf_len_i,
  input  logic [VID_W-1:0]  buf_data_i,
  output logic              buf_rd_o,
  output logic [VID_W-1:0]  vid_o,
  output logic              overflow_o
);
  localparam int unsigned NUM_SLOTS = 2;

  logic              armed, hit;
  logic [LINE_W-1:0] slots [NUM_SLOTS];

  assign slots[0] = line_a_i;
  assign slots[1] = line_b_i;

  anc_arm_ctrl #(.REARM_CYC(REARM_CYC)) u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ins_en_i (ins_en_i),
    .sof_i    (sof_i),
    .mode_i   (mode_i),
    .armed_o  (armed)
  );

  anc_line_match #(.LINE_W(LINE_W), .NUM_SLOTS(NUM_SLOTS)) u_match (
    .line_i      (line_i),
    .slot_line_i (slots),
    .hit_o       (hit)
  );

  anc_ins_engine #(.VID_W(VID_W), .LEN_W(LEN_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .armed_i     (armed),
    .hit_i       (hit),
    .hblank_i    (hblank_i),
    .vid_i       (vid_i),
    .buf_empty_i (buf_empty_i),
    .buf_len_i   (buf_len_i),
    .buf_data_i  (buf_data_i),
    .buf_rd_o    (buf_rd_o),
    .vid_o       (vid_o),
    .overflow_o  (overflow_o)
  );

  AST_ZERO_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i == '0 && hblank_i) |-> !buf_rd_o); // R4
  AST_BYP_NO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYP) |=> (!buf_rd_o || mode_i != MODE_BYP)); // R9
endmodule

// File: tb/sim_anc_line_inserter.sv
`timescale 1ns/1ps
module sim_anc_line_inserter;
  localparam int HB = 8;
  localparam int ACT = 12;
  localparam int NL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  vid_d = '0;
  logic [10:0] line_d = '0;
  logic        sof_d = 1'b0, hb_d = 1'b0, en_d = 1'b0;
  logic [10:0] la_d = '0, lb_d = '0;
  logic [1:0]  mode_d = 2'b00;
  logic        empty_d = 1'b0;
  logic [7:0]  len_d = 8'd5;
  logic [9:0]  ptr = '0;
  logic [9:0]  bdata;
  logic        rd_w, ov_w;
  logic [9:0]  vo_w;

  int n_tests = 0, n_fail = 0;
  logic       rd_seen, obs_ov;
  logic [9:0] obs_vid;

  assign bdata = 10'h040 + ptr;

  always #2.5 clk = ~clk;

  anc_line_inserter u0 (
    .clk_i(clk), .rst_ni(rst_n), .vid_i(vid_d), .line_i(line_d), .sof_i(sof_d),
    .hblank_i(hb_d), .ins_en_i(en_d), .line_a_i(la_d), .line_b_i(lb_d),
    .mode_i(mode_d), .buf_empty_i(empty_d), .buf_len_i(len_d), .buf_data_i(bdata),
    .buf_rd_o(rd_w), .vid_o(vo_w), .overflow_o(ov_w)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int ln, input bit sof, input bit hb, input logic [9:0] v);
    @(negedge clk);
    line_d = 11'(ln); sof_d = sof; hb_d = hb; vid_d = v;
    #1 rd_seen = rd_w;
    @(posedge clk);
    #1;
    if (rd_seen) ptr = ptr + 1'b1;
    obs_vid = vo_w;
    obs_ov  = ov_w;
  endtask

  function automatic logic [9:0] vpat(input int ln, input int k);
    return 10'h200 | 10'(((ln & 15) << 5) | (k & 31));
  endfunction

  // mask bit n set: line n expects a packet of 'words' words; ov: overflow expected
  task automatic run_frame(input logic [7:0] mask, input int words, input bit ov, input string tag);
    int errs = 0;
    int fa = 0, fe = 0;
    for (int ln = 1; ln <= NL; ln++) begin
      ptr = '0;
      for (int k = 0; k < HB; k++) begin
        logic [9:0] v, ev;
        bit ins;
        v = vpat(ln, k);
        cyc(ln, ln == 1 && k == 0, 1'b1, v);
        ins = mask[ln] && (k < words);
        ev = ins ? 10'(10'h040 + k) : v;
        if (obs_vid !== ev || rd_seen !== ins || obs_ov !== 1'b0) begin
          if (errs == 0) begin fa = int'(obs_vid); fe = int'(ev); end
          errs++;
        end
      end
      for (int k = 0; k < ACT; k++) begin
        logic [9:0] v;
        bit eov;
        v = vpat(ln, HB + k);
        cyc(ln, 1'b0, 1'b0, v);
        eov = mask[ln] && ov && (k == 0);
        if (obs_vid !== v || rd_seen !== 1'b0 || obs_ov !== eov) begin
          if (errs == 0) begin fa = int'(obs_vid); fe = int'(v); end
          errs++;
        end
      end
    end
    check(errs == 0, tag, fa, fe);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) cyc(0, 1'b0, 1'b0, 10'h3ff);
    check(vo_w === 10'h000, "R1 vid_o in reset", int'(vo_w), 0);
    check(ov_w === 1'b0 && rd_w === 1'b0, "R1 flags in reset", int'({ov_w, rd_w}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) cyc(0, 1'b0, 1'b0, 10'h155);
    check(obs_vid === 10'h155, "R2 pass after reset", int'(obs_vid), 'h155);
  endtask

  task automatic t_passthrough;
    la_d = 11'd2; lb_d = 11'd5; en_d = 1'b0;
    run_frame(8'h00, 0, 1'b0, "R2 disabled pass-through");
  endtask

  task automatic t_arm;
    la_d = 11'd4; lb_d = 11'd0; len_d = 8'd5; en_d = 1'b1;
    run_frame(8'h00, 0, 1'b0, "R3 no insert in enabling frame");
    run_frame(8'h10, 5, 1'b0, "R3 insert in following frame");
    run_frame(8'h10, 5, 1'b0, "R5 repeat next frame");
  endtask

  task automatic t_lines;
    la_d = 11'd2; lb_d = 11'd5;
    run_frame(8'h24, 5, 1'b0, "R4 both slots");
    la_d = 11'd3; lb_d = 11'd3;
    run_frame(8'h08, 5, 1'b0, "R4 same line once");
    la_d = 11'd0; lb_d = 11'd6;
    run_frame(8'h40, 5, 1'b0, "R4 zero slot unused");
  endtask

  task automatic t_fit;
    la_d = 11'd2; lb_d = 11'd5;
    len_d = 8'd8;
    run_frame(8'h24, 8, 1'b0, "R7 exact fit no flag");
    len_d = 8'd10;
    run_frame(8'h24, 8, 1'b1, "R7 cut at blanking end");
    len_d = 8'd3; empty_d = 1'b1;
    run_frame(8'h00, 0, 1'b0, "R6 empty buffer");
    empty_d = 1'b0; len_d = 8'd0;
    run_frame(8'h00, 0, 1'b0, "R6 zero length");
    len_d = 8'd3;
    run_frame(8'h24, 3, 1'b0, "R6 short packet");
  endtask

  task automatic t_en_drop;
    en_d = 1'b0;
    run_frame(8'h24, 3, 1'b0, "R8 enable low keeps inserting");
    run_frame(8'h24, 3, 1'b0, "R8 second frame");
  endtask

  task automatic t_bypass;
    mode_d = 2'b11;
    run_frame(8'h00, 0, 1'b0, "R9 bypass stops insertion");
  endtask

  task automatic t_rearm_idle;
    en_d = 1'b0; mode_d = 2'b01;
    for (int f = 0; f < 20; f++) run_frame(8'h00, 0, 1'b0, "R10 idle after wait, enable low");
    en_d = 1'b1;
    run_frame(8'h00, 0, 1'b0, "R10 idle needs frame start");
    run_frame(8'h24, 3, 1'b0, "R10 armed via enable");
  endtask

  // mode leaves bypass at sof cycle c; line j starts at c+20j; first legal start c+2201
  task automatic t_rearm_timed;
    int errs = 0;
    mode_d = 2'b11;
    run_frame(8'h00, 0, 1'b0, "R9 bypass held");
    la_d = 11'd3; lb_d = 11'd4; en_d = 1'b1;
    for (int f = 0; f < 20; f++) begin
      logic [7:0] m;
      if (f == 0) mode_d = 2'b10;
      m = '0;
      for (int ln = 1; ln <= NL; ln++) begin
        int j = f * NL + (ln - 1);
        if ((ln == 3 || ln == 4) && (j * (HB + ACT) >= 2201)) m[ln] = 1'b1;
      end
      run_frame(m, 3, 1'b0, "R10 re-arm delay");
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_passthrough();
    t_arm();
    t_lines();
    t_fit();
    t_en_drop();
    t_bypass();
    t_rearm_idle();
    t_rearm_timed();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule